// File: doc/BRIEF.md
# Audio Controller Global Control and Status Register Pair

This block holds the two controller-wide 32-bit registers of a three-channel audio DMA engine: a global control word and a global status word. The three DMA channels (PCM capture, PCM playback, microphone capture) each present a level interrupt. The block copies these levels into three read-only status bits and drives one shared level interrupt line from them through a two-state interrupt machine. Codec-side events set four sticky status bits that software clears by writing ones. The primary codec-ready bit always reads back as set.

Software reaches both registers through a simple register port that carries an offset, an access size and separate read and write strobes. The pair sits after the three 16-byte per-channel windows, at offset 0x30 (control) and 0x34 (status); only full 32-bit accesses reach them. A control write that carries a warm-reset or cold-reset request is dropped whole, because sequencing the codec link resets belongs elsewhere.

The interrupt machine has two states. QUIET: no channel status bit is set and the line is low. RAISED: at least one channel status bit is set and the line is high. Transition RISE goes QUIET to RAISED when any of status bits 7:5 is set; transition SETTLE goes RAISED to QUIET when all three are clear. Each state otherwise holds.

Top module: `glob_stat_ctl`

## Requirements
- R1: After reset the control word reads 0x0000_0000, the status word reads 0x0000_0100, `irq` is low and `reg_rdata` is 0.
- R2: A 32-bit write to offset 0x30 whose data bits 2 and 1 are both 0 loads data[5:0] into the control word; a read returns those six bits with bits 31:6 as 0.
- R3: A 32-bit write to offset 0x30 with data bit 2 or data bit 1 set leaves the control word unchanged.
- R4: Status bits 17 and 16 take the written value on every 32-bit write to offset 0x34.
- R5: Status bits 0, 10, 11 and 15 are set by `sticky_set[0]`, `[1]`, `[2]`, `[3]` respectively, stay set, and clear only when a status write carries a 1 in that position; writing 0 keeps them; a set and a clearing write in the same cycle leave the bit set.
- R6: Status bits 5, 6 and 7 show `chan_irq[0]`, `[1]`, `[2]` (PCM capture, PCM playback, microphone) one clock after the input, and status writes do not change them.
- R7: Status bit 8 always reads 1; status bits 31:18, 14:12, 9, 4:1 always read 0 whatever is written.
- R8: `irq` is high exactly in state RAISED: it rises one clock after any of status bits 7:5 becomes set and falls one clock after all three are clear.
- R9: An access with `reg_size` other than 2 (2 = 32-bit; 0 = byte, 1 = 16-bit) changes no register and reads 0; a read at any offset other than 0x30 or 0x34 reads 0.
- R10: `reg_rdata` is registered: it takes the addressed value at the clock edge where `reg_rd` is high and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_irq | input | 3 | Level interrupts: [0] PCM capture, [1] PCM playback, [2] microphone |
| sticky_set | input | 4 | Codec event pulses setting status bits 0, 10, 11, 15 |
| reg_addr | input | 6 | Byte offset into the controller register space |
| reg_size | input | 2 | Access size: 0 byte, 1 16-bit, 2 32-bit |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Shared level interrupt |

## Verification
A wrong channel bit or a stuck interrupt state shows on `irq` within two clocks of a `chan_irq` change, since the line trails the input by exactly one status register and one state register. A control or status word that took a write it should have dropped, or lost a sticky bit, shows on the very next 32-bit read, one clock after the read strobe. Reads after each write therefore expose every mask and clear rule directly, and the `irq` edges are sampled on the exact cycles the two-register path predicts.

// File: rtl/gcs_pkg.sv
package gcs_pkg;

    localparam int unsigned STA_W      = 18;
    localparam int unsigned CTL_W      = 6;
    localparam int unsigned N_CHAN     = 3;
    localparam int unsigned N_STICKY   = 4;

    // Positions that software decodes
    localparam int unsigned CHAN_BASE  = 5;   // bits 7:5
    localparam int unsigned CREADY_BIT = 8;
    localparam int unsigned RW_LO      = 16;
    localparam int unsigned RW_HI      = 17;
    localparam int unsigned WARM_BIT   = 2;
    localparam int unsigned COLD_BIT   = 1;

    localparam int unsigned STICKY_POS [N_STICKY] = '{0, 10, 11, 15};

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/gcs_ctl_reg.sv
module gcs_ctl_reg
    import gcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wdata,
    output logic [CTL_W-1:0] ctl_q
);

    logic reset_req;
    assign reset_req = wdata[WARM_BIT] | wdata[COLD_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_en && !reset_req) begin
            ctl_q <= wdata;
        end
    end

endmodule

// File: rtl/gcs_sta_reg.sv
module gcs_sta_reg
    import gcs_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [STA_W-1:0]    wdata,
    input  logic [N_CHAN-1:0]   chan_irq,
    input  logic [N_STICKY-1:0] sticky_set,
    output logic [STA_W-1:0]    sta_q
);

    logic [STA_W-1:0] sta_d;
    logic             unused_wd;
    assign unused_wd = ^wdata;

    always_comb begin
        sta_d = sta_q;
        if (wr_en) begin
            sta_d[RW_HI] = wdata[RW_HI];
            sta_d[RW_LO] = wdata[RW_LO];
        end
        for (int i = 0; i < int'(N_STICKY); i++) begin
            if (wr_en && wdata[STICKY_POS[i]]) begin
                sta_d[STICKY_POS[i]] = 1'b0;
            end
            if (sticky_set[i]) begin
                sta_d[STICKY_POS[i]] = 1'b1;
            end
        end
        for (int c = 0; c < int'(N_CHAN); c++) begin
            sta_d[CHAN_BASE + c] = chan_irq[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sta_q <= '0;
        end else begin
            sta_q <= sta_d;
        end
    end

endmodule

// File: rtl/gcs_irq_fsm.sv
module gcs_irq_fsm
    import gcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_chan,
    output logic irq
);

    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (any_chan)  state_d = IRQ_RAISED;  // RISE
            IRQ_RAISED: if (!any_chan) state_d = IRQ_QUIET;   // SETTLE
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            IRQ_RAISED: irq = 1'b1;
            default:    irq = 1'b0;
        endcase
    end

endmodule

// File: rtl/glob_stat_ctl.sv
module glob_stat_ctl
    import gcs_pkg::*;
#(
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned CTL_OFS = 'h30,
    parameter int unsigned STA_OFS = 'h34
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_CHAN-1:0]   chan_irq,
    input  logic [N_STICKY-1:0] sticky_set,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [1:0]          reg_size,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                irq
);

    localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_OFS);
    localparam logic [ADDR_W-1:0] STA_A = ADDR_W'(STA_OFS);

    logic             word_acc, ctl_hit, sta_hit;
    logic [CTL_W-1:0] ctl_q;
    logic [STA_W-1:0] sta_q;
    logic [DATA_W-1:0] sta_view, rd_next;
    logic             unused_wd_hi;

    assign unused_wd_hi = ^reg_wdata[DATA_W-1:STA_W];

    assign word_acc = (acc_size_e'(reg_size) == SZ_WORD);
    assign ctl_hit  = word_acc && (reg_addr == CTL_A);
    assign sta_hit  = word_acc && (reg_addr == STA_A);

    gcs_ctl_reg u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr && ctl_hit),
        .wdata (reg_wdata[CTL_W-1:0]),
        .ctl_q (ctl_q)
    );

    gcs_sta_reg u_sta (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr && sta_hit),
        .wdata      (reg_wdata[STA_W-1:0]),
        .chan_irq   (chan_irq),
        .sticky_set (sticky_set),
        .sta_q      (sta_q)
    );

    gcs_irq_fsm u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_chan (|sta_q[CHAN_BASE +: N_CHAN]),
        .irq      (irq)
    );

    assign sta_view = DATA_W'(sta_q) | (DATA_W'(1) << CREADY_BIT);

    always_comb begin
        rd_next = '0;
        if (ctl_hit)      rd_next = DATA_W'(ctl_q);
        else if (sta_hit) rd_next = sta_view;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_next;
        end
    end

endmodule

// File: rtl/glob_stat_ctl_chk.sv
module glob_stat_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  chan_irq,
    input logic        sticky0,
    input logic        ctl_blocked_wr,
    input logic        sta_rd,
    input logic        narrow_rd,
    input logic [5:0]  ctl_q,
    input logic [2:0]  sta_chan,
    input logic        sta_b0,
    input logic [31:0] reg_rdata,
    input logic        irq
);

    // R3
    ctl_reset_req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_blocked_wr |=> $stable(ctl_q));

    // R6
    chan_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sta_chan == $past(chan_irq)));

    // R5
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sticky0 |=> sta_b0);

    // R7
    cready_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sta_rd |=> reg_rdata[8]);

    // R9
    narrow_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        narrow_rd |=> (reg_rdata == 32'd0));

    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|sta_chan) |=> irq);

    // R8
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|sta_chan) |=> !irq);

endmodule

bind glob_stat_ctl glob_stat_ctl_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .chan_irq       (chan_irq),
    .sticky0        (sticky_set[0]),
    .ctl_blocked_wr (reg_wr && ctl_hit && (reg_wdata[2] || reg_wdata[1])),
    .sta_rd         (reg_rd && sta_hit),
    .narrow_rd      (reg_rd && !word_acc),
    .ctl_q          (ctl_q),
    .sta_chan       (sta_q[7:5]),
    .sta_b0         (sta_q[0]),
    .reg_rdata      (reg_rdata),
    .irq            (irq)
);

// File: tb/glob_stat_ctl_bench.sv
module glob_stat_ctl_bench;

    localparam logic [5:0] CTL = 6'h30;
    localparam logic [5:0] STA = 6'h34;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  chan_irq = '0;
    logic [3:0]  sticky_set = '0;
    logic [5:0]  reg_addr = '0;
    logic [1:0]  reg_size = 2'd2;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    glob_stat_ctl u_glob_stat_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_irq   (chan_irq),
        .sticky_set (sticky_set),
        .reg_addr   (reg_addr),
        .reg_size   (reg_size),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq        (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_size = sz; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_size = 2'd2;
    endtask

    task automatic rd(input logic [5:0] a, input logic [1:0] sz, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_size = sz; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0; reg_size = 2'd2;
        d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 rdata", reg_rdata, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'h0);
        rd(CTL, 2'd2, v); check("R1 ctl", v, 32'h0);
        rd(STA, 2'd2, v); check("R1 sta", v, 32'h100);
    endtask

    task automatic t_ctl();
        logic [31:0] v;
        wr(CTL, 2'd2, 32'hFFFF_FFF9);
        rd(CTL, 2'd2, v); check("R2 ctl load", v, 32'h39);
        wr(CTL, 2'd2, 32'h0000_0004);
        rd(CTL, 2'd2, v); check("R3 warm drop", v, 32'h39);
        wr(CTL, 2'd2, 32'h0000_0002);
        rd(CTL, 2'd2, v); check("R3 cold drop", v, 32'h39);
        wr(CTL, 2'd2, 32'h0000_0000);
        rd(CTL, 2'd2, v); check("R2 ctl zero", v, 32'h0);
    endtask

    task automatic t_rw_bits();
        logic [31:0] v;
        wr(STA, 2'd2, 32'h0003_0000);
        rd(STA, 2'd2, v); check("R4 both set", v, 32'h0003_0100);
        wr(STA, 2'd2, 32'h0001_0000);
        rd(STA, 2'd2, v); check("R4 one set", v, 32'h0001_0100);
        wr(STA, 2'd2, 32'h0);
        rd(STA, 2'd2, v); check("R4 cleared", v, 32'h100);
    endtask

    task automatic t_sticky();
        logic [31:0] v;
        @(negedge clk); sticky_set = 4'hF;
        @(negedge clk); sticky_set = 4'h0;
        rd(STA, 2'd2, v); check("R5 all set", v, 32'h8D01);
        wr(STA, 2'd2, 32'h0000_0400);
        rd(STA, 2'd2, v); check("R5 clear b10", v, 32'h8901);
        wr(STA, 2'd2, 32'h0);
        rd(STA, 2'd2, v); check("R5 zero keeps", v, 32'h8901);
        wr(STA, 2'd2, 32'h0000_8801);
        rd(STA, 2'd2, v); check("R5 clear rest", v, 32'h100);
        @(negedge clk);
        reg_addr = STA; reg_size = 2'd2; reg_wdata = 32'h1; reg_wr = 1'b1; sticky_set = 4'h1;
        @(negedge clk);
        reg_wr = 1'b0; sticky_set = 4'h0;
        rd(STA, 2'd2, v); check("R5 set wins", v, 32'h101);
        wr(STA, 2'd2, 32'h1);
        rd(STA, 2'd2, v); check("R5 final clear", v, 32'h100);
    endtask

    task automatic t_chan();
        logic [31:0] v;
        @(negedge clk); chan_irq = 3'b010;
        @(negedge clk); check("R8 irq lag", {31'd0, irq}, 32'h0);
        @(negedge clk); check("R8 irq rise", {31'd0, irq}, 32'h1);
        rd(STA, 2'd2, v); check("R6 pcm out bit", v, 32'h140);
        wr(STA, 2'd2, 32'h0000_00A0);
        rd(STA, 2'd2, v); check("R6 write no effect", v, 32'h140);
        @(negedge clk); chan_irq = 3'b101;
        @(negedge clk); check("R8 irq held", {31'd0, irq}, 32'h1);
        rd(STA, 2'd2, v); check("R6 two chans", v, 32'h1A0);
        @(negedge clk); chan_irq = 3'b000;
        @(negedge clk); check("R8 irq fall lag", {31'd0, irq}, 32'h1);
        @(negedge clk); check("R8 irq fall", {31'd0, irq}, 32'h0);
        rd(STA, 2'd2, v); check("R6 clear", v, 32'h100);
    endtask

    task automatic t_ro();
        logic [31:0] v;
        wr(STA, 2'd2, 32'hFFFF_FFFF);
        rd(STA, 2'd2, v); check("R7 ro masked", v, 32'h0003_0100);
        wr(STA, 2'd2, 32'h0);
        rd(STA, 2'd2, v); check("R7 cready kept", v, 32'h100);
    endtask

    task automatic t_narrow();
        logic [31:0] v;
        wr(CTL, 2'd1, 32'h11);
        rd(CTL, 2'd2, v); check("R9 half write dropped", v, 32'h0);
        wr(STA, 2'd0, 32'h0003_0000);
        rd(STA, 2'd2, v); check("R9 byte write dropped", v, 32'h100);
        wr(CTL, 2'd2, 32'h11);
        rd(CTL, 2'd0, v); check("R9 byte read zero", v, 32'h0);
        rd(CTL, 2'd2, v); check("R10 word read", v, 32'h11);
        rd(6'h10, 2'd2, v); check("R9 unmapped zero", v, 32'h0);
        rd(CTL, 2'd2, v);
        wr(CTL, 2'd2, 32'h20);
        @(negedge clk); check("R10 rdata holds", reg_rdata, 32'h11);
        rd(CTL, 2'd2, v); check("R10 next read", v, 32'h20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctl();
        t_rw_bits();
        t_sticky();
        t_chan();
        t_ro();
        t_narrow();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule